// File: doc/BRIEF.md
# Serial master clock generator

This block generates the serial clock for a synchronous serial master, either a two-wire bus master or a four-wire shift-register master. A byte engine writes its transmit buffer and pulses `start`. The generator then loads its down-counter from `reload_val` and runs until the byte engine raises `op_done`. When the run ends, the clock output stays at whatever level it had. The counter moves on an enable that fires every second system clock. Each half of the output period lasts `reload_val + 1` enable ticks, so the output frequency is Fsys / (4 × (reload_val + 1)). For example, a 16 MHz system clock with reload 39 gives 100 kHz.

The counter is reloaded once per half period, which is twice per output cycle. Each reload is reported on a one-cycle `reload_pulse`. The 4-bit `mode_sel` chooses the variant. In two-wire mode the clock idles high. After the clock is released high, the high-phase count waits until the line sampled on `scl_in` is really high, so a slave that holds the line low stretches the clock. Reload values below 3 are not usable in two-wire mode. Such a value is replaced by 3, and a sticky error flag is raised.

Control is a three-state machine:
- IDLE: stopped, with the clock held.
- RUN: counting a half period.
- STRETCH: two-wire mode only. The clock has been released high and the block waits for the line.

The transitions are:
- IDLE→RUN on a start in a supported mode.
- RUN→RUN on a half-period expiry that toggles the clock and reloads.
- RUN→STRETCH on expiry of a low half in two-wire mode.
- STRETCH→RUN when `scl_in` is seen high.
- RUN→IDLE and STRETCH→IDLE on `op_done`.

Top module: `serclk_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `clk_out` takes the idle level of the current `mode_sel`: high for 4'h8 (two-wire) and 4'h1 (four-wire, idle high), low for 4'h0 (four-wire, idle low) and for every other code. `reload_pulse` and `cfg_err` go low.
- R2: In IDLE, a `start` sampled with `mode_sel` equal to 4'h0, 4'h1 or 4'h8 loads the counter and raises `reload_pulse` in the following cycle. With any other mode code, `start` is ignored: there is no pulse and the clock does not change.
- R3: In the four-wire modes, `clk_out` toggles every 2 × (R + 1) system clocks, where R is the reload value in use. The first toggle comes 2 × (R + 1) cycles after the start-load edge.
- R4: Every toggle in RUN comes with a reload: `reload_pulse` is high in exactly the cycle where `clk_out` first shows its new level, and it is never high in two consecutive cycles.
- R5: In two-wire mode, expiry of a low half drives `clk_out` high without a reload. The high-half reload (with its pulse) happens on the first following edge at which `scl_in` is high, so an unstretched high half lasts 2 × (R + 1) + 1 cycles.
- R6: In two-wire mode, while `scl_in` is held low after the clock was released, `clk_out` stays high and no `reload_pulse` occurs, for as long as the hold lasts.
- R7: `op_done` in RUN or STRETCH returns the block to IDLE. It takes priority over an expiry at the same edge (no toggle). Afterwards `clk_out` keeps its level and no pulse occurs until the next start.
- R8: `start` while the block is in RUN or STRETCH has no effect on timing.
- R9: In two-wire mode, a reload value of 0, 1 or 2 is loaded as 3 and sets `cfg_err`. `cfg_err` then stays high until reset. Values 0 to 2 in the four-wire modes are used as given and do not set `cfg_err`.
- R10: `reload_val` is sampled at every reload, so a change while running takes effect from the next half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 4 | Mode code: 4'h0 four-wire idle low, 4'h1 four-wire idle high, 4'h8 two-wire |
| reload_val | input | 8 | Half-period reload value R |
| start | input | 1 | Strobe from a transmit-buffer write |
| op_done | input | 1 | Current operation finished |
| scl_in | input | 1 | Sampled level of the bus clock line |
| clk_out | output | 1 | Generated serial clock |
| reload_pulse | output | 1 | One-cycle flag marking a counter reload |
| cfg_err | output | 1 | Sticky flag: illegal two-wire reload value seen |

## Verification
The bench goes after timing edges that a wrong design would shift by a cycle or miss completely:
- **Half-rate enable:** a design that lost its phase reset on reload would drift one cycle per half period.
- **Stretch:** a design that skipped the wait on `scl_in` would pull the clock low while a slave still holds it.
- **Stop coinciding with expiry:** `op_done` is raised exactly at a half-period expiry. A design with the wrong priority would toggle once more.
- **Small reload values:** they are run in both mode families. Clamping in the wrong family would change the four-wire period or leave the error flag clear.
- **Mid-run changes:** an ignored `start` and a changed `reload_val` while running expose a design that restarts, or one that latches the reload value only once.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    localparam int SC_CNT_W  = 8;
    localparam int SC_MODE_W = 4;

    localparam logic [SC_MODE_W-1:0] MODE_FW_LO = 4'h0;
    localparam logic [SC_MODE_W-1:0] MODE_FW_HI = 4'h1;
    localparam logic [SC_MODE_W-1:0] MODE_TW    = 4'h8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_STRETCH = 2'd2
    } sc_state_t;

    function automatic logic mode_is_tw(input logic [SC_MODE_W-1:0] m);
        return (m == MODE_TW);
    endfunction

    function automatic logic mode_is_ok(input logic [SC_MODE_W-1:0] m);
        return (m == MODE_TW) || (m == MODE_FW_LO) || (m == MODE_FW_HI);
    endfunction

    function automatic logic mode_idle_lvl(input logic [SC_MODE_W-1:0] m);
        return (m == MODE_TW) || (m == MODE_FW_HI);
    endfunction

endpackage

// File: rtl/serclk_halfrate.sv
module serclk_halfrate (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic en
);

    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    assign en = ph_q & run;

    AST_EN_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        en |=> !en); // R3

endmodule

// File: rtl/serclk_sanitize.sv
module serclk_sanitize #(
    parameter int CNT_W   = serclk_pkg::SC_CNT_W,
    parameter int MIN_TW  = 3
) (
    input  logic [CNT_W-1:0] raw_val,
    input  logic             is_tw,
    output logic [CNT_W-1:0] use_val,
    output logic             illegal
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TW);

    always_comb begin
        illegal = is_tw && (raw_val < FLOOR);
        use_val = illegal ? FLOOR : raw_val;
    end

    always_comb begin
        AST_CLAMP_FLOOR: assert (!is_tw || (use_val >= FLOOR)); // R9
    end

endmodule

// File: rtl/serclk_downcnt.sv
module serclk_downcnt #(
    parameter int CNT_W = serclk_pkg::SC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero); // R3

endmodule

// File: rtl/serclk_fsm.sv
module serclk_fsm
    import serclk_pkg::*;
#(
    parameter int MODE_W = SC_MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              start,
    input  logic              op_done,
    input  logic              scl_in,
    input  logic              en,
    input  logic              zero,
    input  logic              illegal,
    output logic              load,
    output logic              load_tw,
    output logic              run,
    output logic              clk_out,
    output logic              reload_pulse,
    output logic              cfg_err
);

    sc_state_t         state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic              clk_q, pulse_q, err_q;
    logic              tog, go_hi;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        tog     = 1'b0;
        go_hi   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && mode_is_ok(mode_sel)) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end else if (en && zero) begin
                    if (mode_is_tw(mode_q) && !clk_q) begin
                        go_hi   = 1'b1;
                        state_d = ST_STRETCH;
                    end else begin
                        tog  = 1'b1;
                        load = 1'b1;
                    end
                end
            end
            ST_STRETCH: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end else if (scl_in) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign load_tw = (state_q == ST_IDLE) ? mode_is_tw(mode_sel) : mode_is_tw(mode_q);
    assign run     = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q   <= mode_idle_lvl(mode_sel);
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
            mode_q  <= mode_sel;
        end else begin
            pulse_q <= load;
            if (tog) begin
                clk_q <= ~clk_q;
            end else if (go_hi) begin
                clk_q <= 1'b1;
            end
            if (load && illegal) begin
                err_q <= 1'b1;
            end
            if ((state_q == ST_IDLE) && load) begin
                mode_q <= mode_sel;
            end
        end
    end

    assign clk_out      = clk_q;
    assign reload_pulse = pulse_q;
    assign cfg_err      = err_q;

    AST_IDLE_HOLDS_CLK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> $stable(clk_out)); // R7
    AST_STRETCH_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STRETCH) |-> clk_out); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reload_pulse |=> !reload_pulse); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err); // R9

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int CNT_W  = SC_CNT_W,
    parameter int MODE_W = SC_MODE_W,
    parameter int MIN_TW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              start,
    input  logic              op_done,
    input  logic              scl_in,
    output logic              clk_out,
    output logic              reload_pulse,
    output logic              cfg_err
);

    logic             load, load_tw, run, en, zero, illegal;
    logic [CNT_W-1:0] use_val;

    serclk_sanitize #(.CNT_W(CNT_W), .MIN_TW(MIN_TW)) u_san (
        .raw_val (reload_val),
        .is_tw   (load_tw),
        .use_val (use_val),
        .illegal (illegal)
    );

    serclk_halfrate u_half (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (load),
        .en      (en)
    );

    serclk_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (use_val),
        .en       (en),
        .zero     (zero)
    );

    serclk_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .start        (start),
        .op_done      (op_done),
        .scl_in       (scl_in),
        .en           (en),
        .zero         (zero),
        .illegal      (illegal),
        .load         (load),
        .load_tw      (load_tw),
        .run          (run),
        .clk_out      (clk_out),
        .reload_pulse (reload_pulse),
        .cfg_err      (cfg_err)
    );

endmodule

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mode_sel = 4'h0;
    logic [7:0] reload_val = 8'd5;
    logic       start = 1'b0;
    logic       op_done = 1'b0;
    logic       hold_low = 1'b0;
    logic       scl_in;
    logic       clk_out, reload_pulse, cfg_err;

    always #5 clk = ~clk;

    assign scl_in = clk_out & ~hold_low;

    serclk_gen u_serclk_gen (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .reload_val   (reload_val),
        .start        (start),
        .op_done      (op_done),
        .scl_in       (scl_in),
        .clk_out      (clk_out),
        .reload_pulse (reload_pulse),
        .cfg_err      (cfg_err)
    );

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference: 0 stopped, 1 counting, 2 waiting for line
    int         m_state = 0;
    int         m_left = 0;
    logic       m_clk = 1'b0;
    logic       m_pulse = 1'b0;
    logic       m_err = 1'b0;
    logic [3:0] m_mode = 4'h0;

    function automatic bit ok_mode(input logic [3:0] m);
        return m == 4'h0 || m == 4'h1 || m == 4'h8;
    endfunction

    task automatic m_load(input logic [3:0] m);
        int r;
        r = reload_val;
        if (m == 4'h8 && r < 3) begin
            r = 3;
            m_err = 1'b1;
        end
        m_left = 2 * (r + 1);
        m_pulse = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0;
            m_clk = (mode_sel == 4'h8) || (mode_sel == 4'h1);
            m_pulse = 1'b0;
            m_err = 1'b0;
            m_mode = mode_sel;
            m_left = 0;
        end else begin
            m_pulse = 1'b0;
            case (m_state)
                0: if (start && ok_mode(mode_sel)) begin
                    m_mode = mode_sel;
                    m_load(mode_sel);
                    m_state = 1;
                end
                1: if (op_done) begin
                    m_state = 0;
                end else begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_mode == 4'h8 && !m_clk) begin
                            m_clk = 1'b1;
                            m_state = 2;
                        end else begin
                            m_clk = !m_clk;
                            m_load(m_mode);
                        end
                    end
                end
                default: if (op_done) begin
                    m_state = 0;
                end else if (scl_in) begin
                    m_load(m_mode);
                    m_state = 1;
                end
            endcase
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            check(cur_req, "clk_out", int'(clk_out), int'(m_clk));
            check(cur_req, "reload_pulse", int'(reload_pulse), int'(m_pulse));
            check(cur_req, "cfg_err", int'(cfg_err), int'(m_err));
        end
    end

    always @(negedge clk) begin
        if (!done && cycles > 150000) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] m);
        @(negedge clk);
        rst = 1'b1;
        mode_sel = m;
        start = 1'b0;
        op_done = 1'b0;
        hold_low = 1'b0;
        cyc(2);
        check("R1", "reset clk_out", int'(clk_out), int'((m == 4'h8) || (m == 4'h1)));
        check("R1", "reset reload_pulse", int'(reload_pulse), 0);
        check("R1", "reset cfg_err", int'(cfg_err), 0);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        int seen;
        do_reset(4'h5);
        armed = 1;
        cur_req = "R2";
        reload_val = 8'd5;
        pulse_start();
        cyc(20);
        check("R2", "unsupported mode clk_out", int'(clk_out), 0);

        cur_req = "R1";
        do_reset(4'h0);
        cur_req = "R3";
        reload_val = 8'd2;
        pulse_start();
        check("R2", "pulse after start", int'(reload_pulse), 1);
        cyc(40);
        cur_req = "R8";
        pulse_start();
        cyc(20);
        cur_req = "R10";
        reload_val = 8'd4;
        cyc(50);
        cur_req = "R7";
        seen = 0;
        while (!(m_state == 1 && m_left == 1) && seen < 100) begin
            @(negedge clk);
            seen++;
        end
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        cyc(30);
        cur_req = "R2";
        pulse_start();
        cyc(30);

        cur_req = "R1";
        do_reset(4'h1);
        cur_req = "R4";
        reload_val = 8'd0;
        pulse_start();
        cyc(30);
        check("R9", "four-wire small reload no error", int'(cfg_err), 0);

        cur_req = "R1";
        do_reset(4'h8);
        cur_req = "R5";
        reload_val = 8'd9;
        pulse_start();
        cyc(150);
        cur_req = "R6";
        seen = 0;
        while (m_state != 2 && seen < 100) begin
            @(negedge clk);
            seen++;
        end
        hold_low = 1'b1;
        cyc(40);
        check("R6", "stretched clk_out", int'(clk_out), 1);
        hold_low = 1'b0;
        cyc(100);

        cur_req = "R1";
        do_reset(4'h8);
        cur_req = "R9";
        reload_val = 8'd1;
        pulse_start();
        cyc(60);
        check("R9", "illegal two-wire reload flag", int'(cfg_err), 1);
        reload_val = 8'd20;
        cyc(120);
        check("R9", "flag sticky", int'(cfg_err), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule